// File: doc/BRIEF.md
# Stochastic Bernstein Polynomial Evaluator

The block evaluates a polynomial written in Bernstein form, with every coefficient in the unit interval, by computing on random bit streams. Each cycle, DEG pseudo-random streams whose one-probability equals the input value t are summed by a combinational adder tree. That sum, between 0 and DEG, selects one of DEG+1 coefficient streams, and the selected bit becomes the output stream. Because the sum of DEG independent t-streams equals k with probability C(DEG,k)·t^k·(1−t)^(DEG−k), the output stream's one-probability is the polynomial's value at t.

Values are unsigned fixed point with 2^10 as unity, so 0 means 0.0 and 1024 means 1.0. A start pulse captures t, the coefficient table and the error-injection controls, and then runs a window of 1024 cycles. During the window the output stream's ones are counted. At the end, done pulses for one cycle with the count as an 11-bit result. An injection mode XORs a random flip mask, at a programmable rate, into the t-streams so that the block's tolerance to bit errors can be observed.

Top module: `bse_bernstein_eval`

## Requirements
- R1: After reset, done is 0 and result is 0.
- R2: When the weight count is 0 (t = 0, injection off), the output stream is coefficient stream 0. With coefficient 0 at 1024 the result is 1024, and with it at 0 the result is 0, whatever the other coefficients are.
- R3: When the weight count is DEG (t = 1024, injection off), the output stream is coefficient stream DEG. With coefficient DEG at 1024 the result is 1024, at 0 it is 0, and at 1018 the result is 1017 or 1018.
- R4: done rises exactly 1024 clock edges after the edge that samples start, and stays high for one cycle only.
- R5: t, the coefficients, inj_en and flip_rate are captured on the edge that accepts start. Changes made to them during the window do not affect the result.
- R6: A start pulse during a running window is ignored. It neither restarts the window nor changes the captured inputs.
- R7: With inj_en = 1 and flip_rate = 1024, every t-stream bit is inverted, so t = 0 yields a count of DEG. With inj_en = 0, flip_rate has no effect.
- R8: The result never exceeds 1024. For DEG = 6, t = 512 and coefficients (98, 738, 356, 1023, 719, 993, 1018), the result lies within 751 ± 128.
- R9: The weight count never exceeds DEG. Coefficient k occupies bits [11k+10 : 11k] of coef_flat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an evaluation window when idle |
| t_val | input | 11 | Input value t, 1024 = 1.0 |
| coef_flat | input | 11*(DEG+1) | Coefficient table, coefficient k at bits [11k+10:11k] |
| inj_en | input | 1 | Enables flip injection on the t-streams |
| flip_rate | input | 11 | Probability of a flip per t-stream bit, 1024 = always |
| done | output | 1 | One-cycle pulse at the end of a window |
| result | output | 11 | Count of output-stream ones over the window |

## Verification
The assertions check, on every cycle, that the weight count stays within DEG, that it is zero for a zero t and DEG for a full t when injection is off, that done is a single-cycle pulse, that a running window is not cut short, and that the result stays bounded. Only the bench's scenarios can show that the multiplexer selects the correct coefficient at the extreme counts, that the window latency is 1024, and that inputs are captured and mid-window start pulses ignored. The bench also shows that flips invert the t-streams and that a full polynomial evaluation lands near its expected value.

// File: rtl/bse_pkg.sv
package bse_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_st_t;

  // Distinct non-zero LFSR seed for generator number idx
  function automatic int seed_of(input int idx, input int rnd_w);
    int period;
    period = (1 << rnd_w) - 1;
    return ((idx * 379 + 53) % period) + 1;
  endfunction
endpackage

// File: rtl/bse_stream.sv
module bse_stream #(
  parameter int RND_W = 10,
  parameter logic [RND_W-1:0] TAPS = 10'h240,
  parameter logic [RND_W-1:0] SEED = 10'h001
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RND_W:0] thr,
  output logic           bit_o
);
  logic [RND_W-1:0] lfsr_q, lfsr_n;
  logic             fb;

  always_comb begin
    fb     = ^(lfsr_q & TAPS);
    lfsr_n = {lfsr_q[RND_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_n;
  end

  // one-probability of the stream is thr / 2^RND_W
  assign bit_o = ({1'b0, lfsr_q} < thr);

  a_r9_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/bse_popcount.sv
module bse_popcount #(
  parameter int N  = 6,
  localparam int CW = $clog2(N + 1),
  localparam int LV = $clog2(N),
  localparam int NP = 1 << LV
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int CNT = NP >> l;
    logic [CW-1:0] s [CNT];
    for (genvar j = 0; j < CNT; j++) begin : g_node
      if (l == 0) begin : g_leaf
        if (j < N) begin : g_used
          assign s[j] = CW'(bits[j]);
        end else begin : g_pad
          assign s[j] = '0;
        end
      end else begin : g_add
        assign s[j] = g_lv[l-1].s[2*j] + g_lv[l-1].s[2*j+1];
      end
    end
  end

  assign count = g_lv[LV].s[0];

  always_comb begin
    a_r9_count_range: assert (count <= CW'(N) || $isunknown(bits));
  end
endmodule

// File: rtl/bse_window.sv
module bse_window
  import bse_pkg::*;
#(
  parameter int RND_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           bit_in,
  output logic           busy,
  output logic           done,
  output logic [RND_W:0] result
);
  run_st_t          st_q, st_n;
  logic [RND_W-1:0] cyc_q, cyc_n;
  logic [RND_W:0]   acc_q, acc_n, res_q, res_n;
  logic             done_q, done_n;

  always_comb begin
    st_n   = st_q;
    cyc_n  = cyc_q;
    acc_n  = acc_q;
    res_n  = res_q;
    done_n = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_n  = ST_RUN;
        cyc_n = '0;
        acc_n = '0;
      end
      default: begin
        acc_n = acc_q + (RND_W+1)'(bit_in);
        cyc_n = cyc_q + 1'b1;
        if (cyc_q == '1) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
          res_n  = acc_n;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cyc_q  <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cyc_q  <= cyc_n;
      acc_q  <= acc_n;
      res_q  <= res_n;
      done_q <= done_n;
    end
  end

  assign busy   = (st_q == ST_RUN);
  assign done   = done_q;
  assign result = res_q;

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r6_run_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_q != '1) |=> busy);
  a_r8_result_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result <= (RND_W+1)'(1 << RND_W));
endmodule

// File: rtl/bse_bernstein_eval.sv
module bse_bernstein_eval
  import bse_pkg::*;
#(
  parameter int DEG   = 6,
  parameter int RND_W = 10,
  parameter logic [RND_W-1:0] TAPS = 10'h240
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [RND_W:0]               t_val,
  input  logic [(DEG+1)*(RND_W+1)-1:0] coef_flat,
  input  logic                         inj_en,
  input  logic [RND_W:0]               flip_rate,
  output logic                         done,
  output logic [RND_W:0]               result
);
  localparam int VW = RND_W + 1;
  localparam int CW = $clog2(DEG + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // capture of operands when a window is accepted
  logic                    busy, cap_en;
  logic [VW-1:0]           t_q, rate_q;
  logic [(DEG+1)*VW-1:0]   coef_q;
  logic                    inj_q;

  assign cap_en = start & ~busy;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      t_q    <= '0;
      rate_q <= '0;
      coef_q <= '0;
      inj_q  <= 1'b0;
    end else if (cap_en) begin
      t_q    <= t_val;
      rate_q <= flip_rate;
      coef_q <= coef_flat;
      inj_q  <= inj_en;
    end
  end

  // stream generators
  logic [DEG-1:0] x_raw, x_flip, x_eff;
  logic [DEG:0]   z_bits;

  for (genvar i = 0; i < DEG; i++) begin : g_t
    bse_stream #(.RND_W(RND_W), .TAPS(TAPS),
                 .SEED(RND_W'(seed_of(i, RND_W)))) u_ts (
      .clk(clk), .rst_n(srst_n), .thr(t_q), .bit_o(x_raw[i]));
    bse_stream #(.RND_W(RND_W), .TAPS(TAPS),
                 .SEED(RND_W'(seed_of(2*DEG + 1 + i, RND_W)))) u_fs (
      .clk(clk), .rst_n(srst_n), .thr(rate_q), .bit_o(x_flip[i]));
    assign x_eff[i] = x_raw[i] ^ (inj_q & x_flip[i]);
  end

  for (genvar k = 0; k <= DEG; k++) begin : g_z
    bse_stream #(.RND_W(RND_W), .TAPS(TAPS),
                 .SEED(RND_W'(seed_of(DEG + k, RND_W)))) u_zs (
      .clk(clk), .rst_n(srst_n), .thr(coef_q[k*VW +: VW]), .bit_o(z_bits[k]));
  end

  // weight count selects the coefficient stream
  logic [CW-1:0] w_cnt;
  logic          y_bit;

  bse_popcount #(.N(DEG)) u_pc (.bits(x_eff), .count(w_cnt));

  always_comb begin
    y_bit = 1'b0;
    for (int k = 0; k <= DEG; k++) begin
      if (w_cnt == CW'(k)) y_bit = z_bits[k];
    end
  end

  bse_window #(.RND_W(RND_W)) u_win (
    .clk(clk), .rst_n(srst_n), .start(start), .bit_in(y_bit),
    .busy(busy), .done(done), .result(result));

  a_r2_zero_t_count: assert property (@(posedge clk) disable iff (!srst_n)
    (!inj_q && t_q == '0) |-> w_cnt == '0);
  a_r3_full_t_count: assert property (@(posedge clk) disable iff (!srst_n)
    (!inj_q && t_q == VW'(1 << RND_W)) |-> w_cnt == CW'(DEG));
  a_r5_hold_in_run: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(busy) && busy) |-> $stable(t_q) && $stable(coef_q));
endmodule

// File: tb/bse_bernstein_eval_bench.sv
module bse_bernstein_eval_bench;
  localparam int DEG = 6;
  localparam int VW  = 11;
  localparam int ONE = 1024;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start = 1'b0;
  logic [VW-1:0]          t_val = '0;
  logic [(DEG+1)*VW-1:0]  coef_flat = '0;
  logic                   inj_en = 1'b0;
  logic [VW-1:0]          flip_rate = '0;
  logic                   done;
  logic [VW-1:0]          result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  bse_bernstein_eval #(.DEG(DEG)) u_bse_bernstein_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .t_val(t_val),
    .coef_flat(coef_flat), .inj_en(inj_en), .flip_rate(flip_rate),
    .done(done), .result(result));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // coefficient k at bits [11k+10:11k]  (R9 layout)
  task automatic set_coef(input int c0, input int c1, input int c2, input int c3,
                          input int c4, input int c5, input int c6);
    int v[7];
    v = '{c0, c1, c2, c3, c4, c5, c6};
    for (int k = 0; k <= DEG; k++) coef_flat[k*VW +: VW] = VW'(v[k]);
  endtask

  // one window; optional mid-run change and a second start at edge 500
  task automatic run_win(input bit disturb, output int res, output int lat);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (disturb && lat == 500) begin
        t_val = VW'(ONE); set_coef(0, 0, 0, 0, 0, 0, 0);
        inj_en = 1'b1; flip_rate = VW'(ONE); start = 1'b1;
      end
      if (disturb && lat == 501) start = 1'b0;
    end while (!done && lat < 3000);
    res = result;
    @(negedge clk);
    chk("R4 done single cycle", !done, done, 0);
    chk("R4 latency", lat == 1024, lat, 1024);
  endtask

  task automatic t_reset;
    chk("R1 done after reset", done == 1'b0, done, 0);
    chk("R1 result after reset", result == '0, result, 0);
  endtask

  task automatic t_zero_count;
    int r, l;
    t_val = '0; inj_en = 1'b0; flip_rate = VW'(ONE);
    set_coef(ONE, 0, 0, 0, 0, 0, 0);
    run_win(1'b0, r, l);
    chk("R2 count 0 picks coef0=1024", r == ONE, r, ONE);
    set_coef(0, ONE, ONE, ONE, ONE, ONE, ONE);
    run_win(1'b0, r, l);
    chk("R2 count 0 picks coef0=0", r == 0, r, 0);
    chk("R7 flip_rate ignored when inj off", r == 0, r, 0);
  endtask

  task automatic t_full_count;
    int r, l;
    t_val = VW'(ONE); inj_en = 1'b0;
    set_coef(0, 0, 0, 0, 0, 0, ONE);
    run_win(1'b0, r, l);
    chk("R3 count DEG picks coef6=1024", r == ONE, r, ONE);
    set_coef(ONE, ONE, ONE, ONE, ONE, ONE, 0);
    run_win(1'b0, r, l);
    chk("R3 count DEG picks coef6=0", r == 0, r, 0);
    set_coef(98, 738, 356, 1023, 719, 993, 1018);
    run_win(1'b0, r, l);
    chk("R3 coef6=1018 at t=1", r == 1017 || r == 1018, r, 1018);
  endtask

  task automatic t_inject;
    int r, l;
    t_val = '0; inj_en = 1'b1; flip_rate = VW'(ONE);
    set_coef(0, 0, 0, 0, 0, 0, ONE);
    run_win(1'b0, r, l);
    chk("R7 full flips turn t=0 into count DEG", r == ONE, r, ONE);
    inj_en = 1'b0;
  endtask

  task automatic t_capture_and_restart;
    int r, l;
    t_val = '0; inj_en = 1'b0; flip_rate = '0;
    set_coef(ONE, 0, 0, 0, 0, 0, 0);
    run_win(1'b1, r, l);
    chk("R5 inputs changed mid-window ignored", r == ONE, r, ONE);
    chk("R6 start in window ignored (latency)", l == 1024, l, 1024);
    inj_en = 1'b0; flip_rate = '0;
  endtask

  task automatic t_gamma;
    int r, l;
    t_val = VW'(512); inj_en = 1'b0;
    set_coef(98, 738, 356, 1023, 719, 993, 1018);
    run_win(1'b0, r, l);
    chk("R8 gamma polynomial at t=0.5", r >= 623 && r <= 879, r, 751);
    chk("R8 result bound", r <= ONE, r, ONE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_zero_count();
    t_full_count();
    t_inject();
    t_capture_and_restart();
    t_gamma();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule